// File: doc/BRIEF.md
# Prescaled Memory-Mapped Timer

A 32-bit up-counter peripheral that sits on a simple word-addressed register bus. Software programs a prescale divisor, clears or preloads the count, and then enables the timer. An internal prescale counter runs on every enabled clock. Each time it reaches the programmed divisor it wraps, and the main count advances by one. The count therefore runs at clk/(divisor+1).

Two independent control bits govern the timer. A clear bit forces the count and the prescale counter to zero, whatever the enable bit says. Dropping only the enable bit freezes both counters, so a paused measurement can resume exactly where it stopped.

The block answers any request inside its three-word window with a single-cycle ready pulse. It ignores everything outside that window. The window's base word address is a parameter.

Top module: `prescaled_timer`

## Requirements
- R1: After rst_ni is asserted low, the control, divisor and count registers all read as zero and rdy_o is low.
- R2: The control register sits at word BASE_ADDR, the divisor register at BASE_ADDR+1 and the count at BASE_ADDR+2, with BASE_ADDR defaulting to 389. A request (req_i high for one cycle) in the window raises rdy_o for exactly the following cycle. On a read (we_i low), rdata_o carries the register value in that same cycle.
- R3: Control bit 0 is enable and bit 1 is clear. A control read returns those two stored bits, with bits 31..2 reading as zero.
- R4: While the clear bit is set, the count and the prescale counter are held at zero even if enable is set, and a write to the count leaves it at zero.
- R5: With clear low and enable high, the count advances once per (divisor+1) enabled clocks, starting from a zero prescale counter. A control write takes effect from the clock after the write.
- R6: With clear and enable both low, the count and the prescale counter hold their values. Counting later resumes from both held values.
- R7: With clear low, a write to the count register loads the written value.
- R8: The count wraps silently from 0xFFFFFFFF to 0.
- R9: A request whose address is outside the three-word window leaves rdy_o low and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request, one access per cycle it is high |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| rdy_o | output | 1 | Access acknowledged, one cycle after request |
| rdata_o | output | 32 | Read data, valid while rdy_o is high |

## Verification
The bench pauses and then resumes the timer with a divisor that does not divide the elapsed cycles. A design that cleared the prescale counter on pause would lose ticks, and its final count would fall one short. It sets clear and enable together and writes the count while clear is set. This catches a design that lets enable or a preload beat the clear bit. A preload of 0xFFFFFFFF with divisor zero tests the silent wrap. Writes just above and just below the window must leave all registers unchanged and produce no ready pulse. A loose address decode would fail that check.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DW = 32;
  localparam int NREGS = 3;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_DIV  = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic clr;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/tmr_bus.sv
module tmr_bus
  import tmr_pkg::*;
#(
  parameter int          ADDR_W    = 31,
  parameter int unsigned BASE_ADDR = 389
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     ctrl_rd_i,
  input  logic [DW-1:0]     div_rd_i,
  input  logic [DW-1:0]     cnt_rd_i,
  output logic              wr_ctrl_o,
  output logic              wr_div_o,
  output logic              wr_cnt_o,
  output logic              rdy_o,
  output logic [DW-1:0]     rdata_o
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_ADDR);

  logic [ADDR_W-1:0] offs;
  logic              hit;
  reg_sel_e          sel;
  logic [DW-1:0]     rd_mux;

  // wrap-around subtraction makes addresses below base look far out of window
  assign offs = addr_i - BASE_A;
  assign hit  = req_i && (offs < ADDR_W'(NREGS));

  always_comb begin
    sel = SEL_NONE;
    if (hit) sel = reg_sel_e'(offs[1:0]);
  end

  assign wr_ctrl_o = we_i && (sel == SEL_CTRL);
  assign wr_div_o  = we_i && (sel == SEL_DIV);
  assign wr_cnt_o  = we_i && (sel == SEL_CNT);

  always_comb begin
    unique case (sel)
      SEL_CTRL: rd_mux = ctrl_rd_i;
      SEL_DIV:  rd_mux = div_rd_i;
      SEL_CNT:  rd_mux = cnt_rd_i;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      rdy_o   <= hit;
      rdata_o <= (hit && !we_i) ? rd_mux : '0;
    end
  end

  assert_no_rdy_outside_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !hit) |=> !rdy_o);
  assert_single_cycle_rdy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> rdy_o);
  assert_one_write_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_ctrl_o, wr_div_o, wr_cnt_o}));
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [DW-1:0] div_i,
  output logic          tick_o
);
  logic [DW-1:0] pcnt_q;
  logic          run;

  assign run    = en_i && !clr_i;
  // >= so that lowering the divisor below the running value wraps at once
  assign tick_o = run && (pcnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pcnt_q <= '0;
    else if (clr_i)  pcnt_q <= '0;
    else if (tick_o) pcnt_q <= '0;
    else if (run)    pcnt_q <= pcnt_q + 1'b1;
  end

  assert_clr_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (pcnt_q == '0));
  assert_pause_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !en_i) |=> $stable(pcnt_q));
  assert_no_tick_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !tick_o);
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          ld_i,
  input  logic [DW-1:0] ld_data_i,
  input  logic          tick_i,
  output logic [DW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (ld_i)   cnt_o <= ld_data_i;
    else if (tick_i) cnt_o <= cnt_o + 1'b1;
  end

  assert_clr_beats_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0));
  assert_load_value_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && ld_i) |=> (cnt_o == $past(ld_data_i)));
  assert_step_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !ld_i && tick_i) |=> (cnt_o == $past(cnt_o) + 1'b1));
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !ld_i && !tick_i) |=> $stable(cnt_o));
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import tmr_pkg::*;
#(
  parameter int          ADDR_W    = 31,
  parameter int unsigned BASE_ADDR = 389
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic              rdy_o,
  output logic [DW-1:0]     rdata_o
);
  ctrl_t         ctrl_q;
  logic [DW-1:0] div_q;
  logic [DW-1:0] cnt;
  logic          wr_ctrl, wr_div, wr_cnt, tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      div_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(wdata_i[1:0]);
      if (wr_div)  div_q  <= wdata_i;
    end
  end

  tmr_bus #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_bus (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .ctrl_rd_i ({{(DW-2){1'b0}}, ctrl_q}),
    .div_rd_i  (div_q),
    .cnt_rd_i  (cnt),
    .wr_ctrl_o (wr_ctrl),
    .wr_div_o  (wr_div),
    .wr_cnt_o  (wr_cnt),
    .rdy_o     (rdy_o),
    .rdata_o   (rdata_o)
  );

  tmr_prescale u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ctrl_q.clr),
    .en_i   (ctrl_q.en),
    .div_i  (div_q),
    .tick_o (tick)
  );

  tmr_count u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (ctrl_q.clr),
    .ld_i      (wr_cnt),
    .ld_data_i (wdata_i),
    .tick_i    (tick),
    .cnt_o     (cnt)
  );

  assert_ctrl_upper_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == ADDR_W'(BASE_ADDR)) |=> (rdata_o[DW-1:2] == '0));
endmodule

// File: tb/prescaled_timer_test.sv
module prescaled_timer_test;
  localparam int AW = 31;
  localparam int unsigned BASE = 389;
  localparam logic [AW-1:0] A_CTRL = AW'(BASE);
  localparam logic [AW-1:0] A_DIV  = AW'(BASE + 1);
  localparam logic [AW-1:0] A_CNT  = AW'(BASE + 2);
  localparam int NV = 5;
  // divisor, idle cycles after enable write, expected count = (W+1)/(P+1)
  localparam logic [31:0] V_DIV  [NV] = '{32'd0, 32'd1, 32'd3, 32'd4, 32'd6};
  localparam logic [31:0] V_WAIT [NV] = '{32'd9, 32'd9, 32'd10, 32'd13, 32'd5};
  localparam logic [31:0] V_EXP  [NV] = '{32'd10, 32'd5, 32'd2, 32'd2, 32'd0};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic          rdy;
  logic [31:0]   rdata;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  prescaled_timer #(.ADDR_W(AW), .BASE_ADDR(BASE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdy_o(rdy), .rdata_o(rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic exp_rdy);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    check(exp_rdy ? "R2 write ready" : "R9 no ready outside", {31'd0, rdy}, {31'd0, exp_rdy});
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    check("R2 read ready", {31'd0, rdy}, 32'd1);
    d = rdata;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    check("R1 rdy in reset", {31'd0, rdy}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(A_CTRL, v); check("R1 ctrl after reset", v, 32'd0);
    rd(A_DIV, v);  check("R1 div after reset", v, 32'd0);
    rd(A_CNT, v);  check("R1 count after reset", v, 32'd0);
    @(negedge clk);
    check("R2 rdy drops after one cycle", {31'd0, rdy}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      wr(A_CTRL, 32'd2, 1'b1);
      wr(A_CTRL, 32'd0, 1'b1);
      wr(A_DIV, V_DIV[i], 1'b1);
      wr(A_CTRL, 32'd1, 1'b1);
      repeat (V_WAIT[i]) @(negedge clk);
      wr(A_CTRL, 32'd0, 1'b1);
      rd(A_CNT, v);
      check($sformatf("R5 rate vector %0d", i), v, V_EXP[i]);
    end

    // R6 pause keeps prescale phase: div 4, 7 then 3 enabled clocks
    wr(A_CTRL, 32'd2, 1'b1);
    wr(A_CTRL, 32'd0, 1'b1);
    wr(A_DIV, 32'd4, 1'b1);
    wr(A_CTRL, 32'd1, 1'b1);
    repeat (6) @(negedge clk);
    wr(A_CTRL, 32'd0, 1'b1);
    repeat (5) @(negedge clk);
    rd(A_CNT, v); check("R6 held while paused", v, 32'd1);
    wr(A_CTRL, 32'd1, 1'b1);
    repeat (2) @(negedge clk);
    wr(A_CTRL, 32'd0, 1'b1);
    rd(A_CNT, v); check("R6 resume keeps prescale", v, 32'd2);

    // R3 control readback masks upper bits; R4 clear beats enable and load
    wr(A_CTRL, 32'hFFFF_FFFF, 1'b1);
    rd(A_CTRL, v); check("R3 ctrl readback", v, 32'd3);
    repeat (6) @(negedge clk);
    rd(A_CNT, v); check("R4 clear with enable holds zero", v, 32'd0);
    wr(A_CNT, 32'd55, 1'b1);
    rd(A_CNT, v); check("R4 load ignored in clear", v, 32'd0);
    wr(A_CTRL, 32'd0, 1'b1);
    rd(A_CTRL, v); check("R3 ctrl cleared", v, 32'd0);

    // R7 preload while idle
    wr(A_CNT, 32'd123, 1'b1);
    rd(A_CNT, v); check("R7 preload", v, 32'd123);

    // R9 neighbours outside window
    wr(A_DIV, 32'd7, 1'b1);
    wr(A_CNT + 1'b1, 32'h55, 1'b0);
    wr(A_CTRL - 1'b1, 32'h66, 1'b0);
    rd(A_DIV, v);  check("R9 div untouched", v, 32'd7);
    rd(A_CNT, v);  check("R9 count untouched", v, 32'd123);
    rd(A_CTRL, v); check("R9 ctrl untouched", v, 32'd0);

    // R8 wrap: divisor 0, one enabled clock from all ones
    wr(A_DIV, 32'd0, 1'b1);
    wr(A_CNT, 32'hFFFF_FFFF, 1'b1);
    wr(A_CTRL, 32'd1, 1'b1);
    wr(A_CTRL, 32'd0, 1'b1);
    rd(A_CNT, v); check("R8 wrap to zero", v, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule